// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a per-core countdown timer that feeds the interrupt request logic. Its counter is advanced by a bus-cycle tick that first passes through a programmable power-of-two prescaler. Software loads an initial count, picks a divisor and programs a timer entry that holds the vector, a mask bit and a periodic bit. It can read back every register and the live count.

When the count runs out, the block raises a request carrying the programmed vector toward the priority logic. The priority logic acknowledges the request once it has taken the vector. An expiry can arrive while the request is still outstanding. Such expiries go into a saturating pending counter, so bursts are not lost, and each acknowledge hands one of them back as a fresh request.

The block is used through a simple register write port, a combinational read port selected by a 2-bit code, and a request/acknowledge pair. Address decoding and any wall-clock conversion of the tick stay outside the block.

Top module: `lct_timer`

## Requirements
- R1: Register select codes are 0 initial count, 1 current count (read-only, writes ignored), 2 divide configuration, 3 timer entry. The divisor is 2 raised to the power (({cfg[3],cfg[1],cfg[0]}) + 1) mod 8. Configuration bit 2 plays no part, so code 111 gives a divisor of 1 and the other codes give 2 to 128.
- R2: Writing the initial count loads that value into the current count on the same clock edge. The same write clears the prescaler phase, so a full divisor of ticks passes before the next decrement.
- R3: The current count decrements once for every divisor-many cycles in which `tick_i` is high. It does not change while `tick_i` is low.
- R4: In periodic mode (entry bit 17 = 1), the edge on which the count would reach zero reloads it from the initial count instead, and counting continues.
- R5: In one-shot mode (entry bit 17 = 0), the count reaches zero and then stays at zero.
- R6: An expiry raises no request while the entry is masked (entry bit 16 = 1) or while `en_i` is low. This holds at the time of expiry and also after the mask is cleared or `en_i` is raised again.
- R7: An expiry sets the request on the edge at which the count expires. If the request is already set, the pending counter increments instead. An acknowledge of a set request consumes one pending expiry and keeps the request up while any remain; otherwise it clears the request.
- R8: The pending counter saturates at 2^PEND_W-1 and does not wrap.
- R9: An initial count of zero leaves the timer idle: the count stays zero and no request is raised.
- R10: The timer entry keeps only the vector (bits 7:0), mask (bit 16) and periodic (bit 17); all other written bits read as zero. Bit 12 reads back as delivery status, which equals the request output.
- R11: After reset the entry reads masked with vector 0 and one-shot mode, the counts and divide configuration read zero, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bus-cycle tick that feeds the prescaler |
| en_i | input | 1 | Controller enable; when low, expiries raise nothing |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write register select |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read register select |
| rd_data_o | output | 32 | Read data (combinational) |
| irq_req_o | output | 1 | Interrupt request toward the priority logic |
| irq_vec_o | output | VEC_W | Vector carried with the request |
| irq_ack_i | input | 1 | Acknowledge of the current request |

## Verification
The bench builds the block with a 32-bit count and PEND_W = 2, so the pending counter saturates at 3. With this setting, a run of six back-to-back periodic expiries is enough to show that the counter holds at its maximum instead of wrapping. It sweeps divide codes that include the largest divisor and the divisor of 1, and a code with the unused bit set, so the whole prescaler decode is reached within a few hundred cycles. Short periodic runs with a divisor of 1 bring overlapping expiries, acknowledge re-raise and mask or disable suppression within a few tens of cycles.

// File: rtl/lct_pkg.sv
package lct_pkg;
  typedef enum logic [1:0] {
    SEL_INIT  = 2'd0,
    SEL_CUR   = 2'd1,
    SEL_DIV   = 2'd2,
    SEL_ENTRY = 2'd3
  } reg_sel_e;

  localparam int unsigned DATA_W       = 32;
  localparam int unsigned CFG_W        = 4;
  localparam int unsigned ENT_STAT_BIT = 12;
  localparam int unsigned ENT_MASK_BIT = 16;
  localparam int unsigned ENT_PER_BIT  = 17;
endpackage

// File: rtl/lct_prescale.sv
module lct_prescale #(
  parameter int unsigned CODE_W = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       tick_i,
  input  logic [lct_pkg::CFG_W-1:0]  cfg_i,
  output logic                       step_o
);
  localparam int unsigned PCNT_W = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] code;
  logic [PCNT_W-1:0] lim, pres_q;

  // cfg bit 2 is not part of the code
  assign code = CODE_W'({cfg_i[3], cfg_i[1:0]}) + CODE_W'(1);
  assign lim  = PCNT_W'((32'd1 << code) - 32'd1);
  assign step_o = tick_i && !clr_i && (pres_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pres_q <= '0;
    else if (clr_i)                pres_q <= '0;
    else if (tick_i) begin
      if (pres_q == lim)           pres_q <= '0;
      else                         pres_q <= pres_q + PCNT_W'(1);
    end
  end

  AST_STEP_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> tick_i); // R3
  AST_CLR_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !step_o || (lim == '0)); // R2
endmodule

// File: rtl/lct_count.sv
module lct_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] init_o,
  output logic [CNT_W-1:0] cur_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] init_q, cur_q;
  logic             run_q;

  assign init_o   = init_q;
  assign cur_o    = cur_q;
  assign expire_o = !load_i && run_q && step_i && (cur_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      cur_q  <= '0;
      run_q  <= 1'b0;
    end else if (load_i) begin
      init_q <= load_val_i;
      cur_q  <= load_val_i;
      run_q  <= (load_val_i != '0);
    end else if (run_q && step_i) begin
      if (cur_q == CNT_W'(1)) begin
        if (periodic_i) cur_q <= init_q;
        else begin
          cur_q <= '0;
          run_q <= 1'b0;
        end
      end else begin
        cur_q <= cur_q - CNT_W'(1);
      end
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cur_q == $past(load_val_i)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !load_i) |=> cur_q == $past(cur_q)); // R5
  AST_NO_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> cur_q == $past(cur_q)); // R3
endmodule

// File: rtl/lct_pend.sv
module lct_pend #(
  parameter int unsigned PEND_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic ack_i,
  output logic req_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic              req_q, req_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              take;

  assign take  = ack_i && req_q;
  assign req_o = req_q;

  always_comb begin
    req_d  = req_q;
    pend_d = pend_q;
    if (hit_i && take) begin
      req_d = 1'b1;  // one consumed, one added
    end else if (hit_i) begin
      if (!req_q)                req_d  = 1'b1;
      else if (pend_q != PEND_MAX) pend_d = pend_q + PEND_W'(1);
    end else if (take) begin
      if (pend_q != '0) pend_d = pend_q - PEND_W'(1);
      else              req_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= '0;
    end else begin
      req_q  <= req_d;
      pend_q <= pend_d;
    end
  end

  AST_PEND_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != '0) |-> req_q); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == PEND_MAX && hit_i && !ack_i) |=> pend_q == PEND_MAX); // R8
  AST_HIT_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> req_q); // R7
endmodule

// File: rtl/lct_timer.sv
module lct_timer #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PEND_W = 4,
  parameter int unsigned VEC_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [31:0]      wr_data_i,
  input  logic [1:0]       rd_sel_i,
  output logic [31:0]      rd_data_o,
  output logic             irq_req_o,
  output logic [VEC_W-1:0] irq_vec_o,
  input  logic             irq_ack_i
);
  import lct_pkg::*;

  localparam logic [CFG_W-1:0] CFG_KEEP = 4'b1011;

  logic [CFG_W-1:0] cfg_q;
  logic [VEC_W-1:0] vec_q;
  logic             mask_q, per_q;
  logic             load, step, expire, hit;
  logic [CNT_W-1:0] init_cnt, cur_cnt;
  logic [DATA_W-1:0] entry_rd;

  assign load = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_INIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      vec_q  <= '0;
      mask_q <= 1'b1;
      per_q  <= 1'b0;
    end else if (wr_en_i) begin
      case (reg_sel_e'(wr_sel_i))
        SEL_DIV:   cfg_q <= wr_data_i[CFG_W-1:0] & CFG_KEEP;
        SEL_ENTRY: begin
          vec_q  <= wr_data_i[VEC_W-1:0];
          mask_q <= wr_data_i[ENT_MASK_BIT];
          per_q  <= wr_data_i[ENT_PER_BIT];
        end
        default: ;
      endcase
    end
  end

  lct_prescale #(.CODE_W(3)) i_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .tick_i (tick_i),
    .cfg_i  (cfg_q),
    .step_o (step)
  );

  lct_count #(.CNT_W(CNT_W)) i_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (wr_data_i[CNT_W-1:0]),
    .step_i     (step),
    .periodic_i (per_q),
    .init_o     (init_cnt),
    .cur_o      (cur_cnt),
    .expire_o   (expire)
  );

  assign hit = expire && !mask_q && en_i;

  lct_pend #(.PEND_W(PEND_W)) i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .ack_i  (irq_ack_i),
    .req_o  (irq_req_o)
  );

  assign irq_vec_o = vec_q;

  always_comb begin
    entry_rd               = '0;
    entry_rd[VEC_W-1:0]    = vec_q;
    entry_rd[ENT_STAT_BIT] = irq_req_o;
    entry_rd[ENT_MASK_BIT] = mask_q;
    entry_rd[ENT_PER_BIT]  = per_q;
  end

  always_comb begin
    case (reg_sel_e'(rd_sel_i))
      SEL_INIT:  rd_data_o = DATA_W'(init_cnt);
      SEL_CUR:   rd_data_o = DATA_W'(cur_cnt);
      SEL_DIV:   rd_data_o = DATA_W'(cfg_q);
      default:   rd_data_o = entry_rd;
    endcase
  end

  AST_MASK_NO_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_req_o && (mask_q || !en_i)) |=> !irq_req_o); // R6
  AST_VEC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_ENTRY)) |=> $stable(irq_vec_o)); // R10
endmodule

// File: tb/test_lct_timer.sv
module test_lct_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        en = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        req;
  logic [7:0]  vec;
  logic        ack = 1'b0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  lct_timer #(.CNT_W(32), .PEND_W(2), .VEC_W(8)) i_lct_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_i(en),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .irq_req_o(req), .irq_vec_o(vec), .irq_ack_i(ack)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    rd_sel = sel; #1; d = rd_data;
  endtask

  task automatic do_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3, d); check("R11 entry", d, 32'h0001_0000);
    rd(1, d); check("R11 cur", d, 0);
    rd(2, d); check("R11 cfg", d, 0);
    check("R11 req", {31'd0, req}, 0);
  endtask

  task automatic t_entry();
    logic [31:0] d;
    wr(3, 32'hFFFF_FFFF);
    rd(3, d); check("R10 entry fields", d, 32'h0003_00FF);
    wr(1, 32'h1234);
    rd(1, d); check("R1 cur read-only", d, 0);
    wr(2, 32'hF);
    rd(2, d); check("R1 cfg bit2 dropped", d, 32'hB);
  endtask

  task automatic t_div();
    logic [31:0] d;
    logic [3:0] cfgs [6] = '{4'h0, 4'h3, 4'hA, 4'hB, 4'h4, 4'h8};
    int         divs [6] = '{2, 16, 128, 1, 2, 32};
    for (int i = 0; i < 6; i++) begin
      wr(2, {28'd0, cfgs[i]});
      wr(3, 32'h40);
      wr(0, 3);
      repeat (3 * divs[i] - 1) @(negedge clk);
      rd(1, d); check("R1 R3 count before expiry", d, 1);
      check("R5 no early req", {31'd0, req}, 0);
      @(negedge clk);
      rd(1, d); check("R5 count zero", d, 0);
      check("R7 req on expiry", {31'd0, req}, 1);
      check("R7 vector", {24'd0, vec}, 32'h40);
      rd(3, d); check("R10 status bit", d, 32'h0000_1040);
      do_ack();
      check("R7 ack clears", {31'd0, req}, 0);
    end
    repeat (20) @(negedge clk);
    rd(1, d); check("R5 stays zero", d, 0);
  endtask

  task automatic t_restart();
    logic [31:0] d;
    wr(2, 32'h1);   // divisor 4
    wr(0, 10);
    repeat (2) @(negedge clk);
    wr(0, 10);
    repeat (3) @(negedge clk);
    rd(1, d); check("R2 prescaler cleared", d, 10);
    @(negedge clk);
    rd(1, d); check("R2 first step", d, 9);
    wr(0, 5);
    rd(1, d); check("R2 reload value", d, 5);
    wr(2, 32'hB);
    tick = 1'b0;
    wr(0, 5);
    repeat (6) @(negedge clk);
    rd(1, d); check("R3 no tick hold", d, 5);
    tick = 1'b1;
    @(negedge clk);
    rd(1, d); check("R3 tick step", d, 4);
    wr(0, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    wr(2, 32'hB);
    wr(3, 32'h0002_0055);
    wr(0, 4);
    repeat (4) @(negedge clk);
    rd(1, d); check("R4 reload", d, 4);
    check("R7 periodic req", {31'd0, req}, 1);
    repeat (4) @(negedge clk);
    do_ack();
    check("R7 re-raise after ack", {31'd0, req}, 1);
    do_ack();
    check("R7 drained", {31'd0, req}, 0);
    wr(0, 0);
    repeat (10) @(negedge clk);
    rd(1, d); check("R9 idle count", d, 0);
    check("R9 no req", {31'd0, req}, 0);
  endtask

  task automatic t_sat();
    wr(3, 32'h0002_0077);
    wr(0, 2);
    repeat (12) @(negedge clk);
    wr(0, 0);
    repeat (3) do_ack();
    check("R8 saturated pending", {31'd0, req}, 1);
    do_ack();
    check("R8 all consumed", {31'd0, req}, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(3, 32'h0001_0040);
    wr(0, 3);
    repeat (5) @(negedge clk);
    rd(1, d); check("R6 masked expired", d, 0);
    check("R6 masked no req", {31'd0, req}, 0);
    wr(3, 32'h40);
    check("R6 unmask no late req", {31'd0, req}, 0);
    en = 1'b0;
    wr(0, 3);
    repeat (5) @(negedge clk);
    check("R6 disabled no req", {31'd0, req}, 0);
    en = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 enable no late req", {31'd0, req}, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_entry();
    t_div();
    t_restart();
    t_periodic();
    t_sat();
    t_mask();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule